// File: doc/BRIEF.md
# Card Host Interrupt Aggregator

This block gathers the event sources of a removable-card host interface and turns them into one processor interrupt line. Events first land in a local status register with its own enable mask; the masked local state then sets one bit of a small global status register. The global register also holds a bit belonging to a sibling storage controller. Two global masks, one for status and one for signalling, must both be set for a global bit to drive the interrupt output.

The block also watches the two card-detect pins and two ready inputs through synchronizers. A card counts as present only while both detect pins are low. Each insertion or removal sets a detect bit in the local status register. Software reads and writes every register through a simple word-addressed port. Status registers clear by writing ones; writing zeros leaves them unchanged.

Top module: `cfh_irq_aggregator`

## Requirements
- R1: Local status bits are set by their events whether or not they are enabled: bit 0 detect change, bit 1 `ev_stat_chg`, bit 2 `ev_mem_mode`, bit 3 `ev_io_mode`, bit 8 `ev_ide_mode`, bit 9 `ev_xfer_err`, bit 10 `ev_buf_avail`, bit 11 `ev_xfer_done`. An event that is high at a rising clock edge is visible in the register after that edge. All other bits read 0.
- R2: Writing to the local status register (word address 1) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R3: When a set and a write-one clear hit the same status bit at the same edge, the bit stays set. This holds for local and global status.
- R4: The register map uses word addresses: 0 interface status (read-only), 1 local status, 2 local enable (same bit layout as local status; unused bits read 0), 3 global status, 4 global status-enable (bits 1:0), 5 global signal-enable (bits 1:0). Addresses 6 and 7 read 0 and ignore writes.
- R5: Global status bit 0 is set at the edge after one where any local status bit is both set and enabled.
- R6: Global status bit 1 is set at the edge where `sib_evt` is high. Writing a 1 to a global status bit clears it.
- R7: `irq_o` is high exactly when some global status bit has both its status-enable and its signal-enable bit set.
- R8: A card is present only when both `cd1_n` and `cd2_n` are low after synchronization. Every change of presence sets local status bit 0, two edges after the pins are synchronized. One pin alone low never counts as insertion.
- R9: The interface status register reads bit 0 presence, bit 2 synchronized `cd1_n`, bit 3 synchronized `cd2_n`, bit 5 synchronized `card_rdy` and bit 6 synchronized `io_rdy`. Each input passes through two flops.
- R10: After reset all status and enable registers read 0, presence reads absent, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ev_xfer_err | input | 1 | Transfer error event |
| ev_buf_avail | input | 1 | Buffer available event |
| ev_xfer_done | input | 1 | Transfer done event |
| ev_stat_chg | input | 1 | Status change event |
| ev_mem_mode | input | 1 | Memory-mode event |
| ev_io_mode | input | 1 | I/O-mode event |
| ev_ide_mode | input | 1 | Disk-register-mode event |
| sib_evt | input | 1 | Event from the sibling controller |
| cd1_n | input | 1 | Card-detect pin 1, low when seated |
| cd2_n | input | 1 | Card-detect pin 2, low when seated |
| card_rdy | input | 1 | Card ready input |
| io_rdy | input | 1 | I/O ready input |
| irq_o | output | 1 | Interrupt output |

## Verification
The hardest case to reach is a write-one clear of the global bit that lands on the same edge as a re-set. This happens when the clear comes from a local bit that is still enabled, and the clear then has no effect. The bench reaches it by clearing global status before clearing the local cause. It reaches the local version of the same collision by raising an event during the write that clears that event's bit. Card handling is driven through partial insertion (one pin low for several cycles), full insertion and removal. A seeded random phase then mixes events, sibling pulses and writes to every address, while a behavioural model is compared on each clock.

// File: rtl/cfh_irq_pkg.sv
package cfh_irq_pkg;
    localparam int LST_W = 12;
    localparam int GL_W  = 2;

    // local status / enable bit positions
    localparam int B_DET  = 0;
    localparam int B_SCHG = 1;
    localparam int B_MEM  = 2;
    localparam int B_IO   = 3;
    localparam int B_IDE  = 8;
    localparam int B_XERR = 9;
    localparam int B_BUF  = 10;
    localparam int B_DONE = 11;
    localparam logic [LST_W-1:0] LST_IMPL = 12'hF0F;

    // interface status bit positions
    localparam int IF_PRES  = 0;
    localparam int IF_CD1   = 2;
    localparam int IF_CD2   = 3;
    localparam int IF_RDY   = 5;
    localparam int IF_IORDY = 6;

    // global bits
    localparam int G_CARD = 0;
    localparam int G_SIB  = 1;

    typedef enum logic [2:0] {
        RA_IFSTAT = 3'd0,
        RA_LSTAT  = 3'd1,
        RA_LEN    = 3'd2,
        RA_GSTAT  = 3'd3,
        RA_GSEN   = 3'd4,
        RA_GSIG   = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/cfh_pin_sync.sv
module cfh_pin_sync #(
    parameter int N = 4,
    parameter int STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [STAGES-1:0][N-1:0] chain_d, chain_q;

    assign chain_d[0] = din;
    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            assign chain_d[g] = chain_q[g-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/cfh_card_sense.sv
module cfh_card_sense #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cd1_n,
    input  logic cd2_n,
    input  logic card_rdy,
    input  logic io_rdy,
    output logic cd1_s,
    output logic cd2_s,
    output logic rdy_s,
    output logic iordy_s,
    output logic present,
    output logic det_evt
);
    typedef struct packed {
        logic present;
    } cs_state_t;

    cs_state_t st_d, st_q;
    logic [3:0] pins_s;

    cfh_pin_sync #(.N(4), .STAGES(STAGES), .RST_VAL(4'b0011)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({io_rdy, card_rdy, cd2_n, cd1_n}),
        .dout (pins_s)
    );

    assign cd1_s   = pins_s[0];
    assign cd2_s   = pins_s[1];
    assign rdy_s   = pins_s[2];
    assign iordy_s = pins_s[3];

    always_comb begin
        st_d = st_q;
        st_d.present = !cd1_s && !cd2_s;
        det_evt = (st_d.present != st_q.present);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign present = st_q.present;

    // R8: presence only follows a cycle where both synced pins were low
    p_present_pins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        present |-> $past(!cd1_s && !cd2_s));
endmodule

// File: rtl/cfh_local_tier.sv
module cfh_local_tier #(
    parameter int W = 12,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         wr_stat,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] en_o,
    output logic         pend_o
);
    typedef struct packed {
        logic [W-1:0] stat;
        logic [W-1:0] en;
    } lt_state_t;

    lt_state_t st_d, st_q;
    logic [W-1:0] clr_v;

    always_comb begin
        st_d  = st_q;
        clr_v = wr_stat ? wdata : '0;
        st_d.stat = ((st_q.stat & ~clr_v) | set_i) & IMPL;
        if (wr_en) st_d.en = wdata & IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;
    assign en_o   = st_q.en;
    assign pend_o = |(st_q.stat & st_q.en);

    // R2: a written one without a concurrent event leaves the bit clear
    p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.stat & $past(clr_v & ~set_i & IMPL)) == '0));
    // R1/R3: an event sets its bit even against a same-edge clear
    p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.stat & $past(set_i & IMPL)) == $past(set_i & IMPL)));
endmodule

// File: rtl/cfh_global_tier.sv
module cfh_global_tier #(
    parameter int G = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [G-1:0] set_i,
    input  logic         wr_stat,
    input  logic         wr_sen,
    input  logic         wr_sig,
    input  logic [G-1:0] wdata,
    output logic [G-1:0] stat_o,
    output logic [G-1:0] sen_o,
    output logic [G-1:0] sig_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [G-1:0] stat;
        logic [G-1:0] sen;
        logic [G-1:0] sig;
    } gt_state_t;

    gt_state_t st_d, st_q;
    logic [G-1:0] clr_v;

    always_comb begin
        st_d  = st_q;
        clr_v = wr_stat ? wdata : '0;
        st_d.stat = (st_q.stat & ~clr_v) | set_i;
        if (wr_sen) st_d.sen = wdata;
        if (wr_sig) st_d.sig = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;
    assign sen_o  = st_q.sen;
    assign sig_o  = st_q.sig;
    assign irq_o  = |(st_q.stat & st_q.sen & st_q.sig);

    // R3: set beats clear on global bits
    p_gset_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.stat & $past(set_i)) == $past(set_i)));
    // R6: written one clears when nothing sets it
    p_gw1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.stat & $past(clr_v & ~set_i)) == '0));
endmodule

// File: rtl/cfh_irq_aggregator.sv
module cfh_irq_aggregator
    import cfh_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_xfer_err,
    input  logic              ev_buf_avail,
    input  logic              ev_xfer_done,
    input  logic              ev_stat_chg,
    input  logic              ev_mem_mode,
    input  logic              ev_io_mode,
    input  logic              ev_ide_mode,
    input  logic              sib_evt,
    input  logic              cd1_n,
    input  logic              cd2_n,
    input  logic              card_rdy,
    input  logic              io_rdy,
    output logic              irq_o
);
    localparam int LW = LST_W;
    localparam int GW = GL_W;

    logic cd1_s, cd2_s, rdy_s, iordy_s, present, det_evt;
    logic [LW-1:0] l_set, l_stat, l_en;
    logic l_pend;
    logic [GW-1:0] g_set, g_stat, g_sen, g_sig;
    logic wr_lstat, wr_len, wr_gstat, wr_gsen, wr_gsig;

    cfh_card_sense #(.STAGES(SYNC_STAGES)) u_sense (
        .clk     (clk),
        .rst_n   (rst_n),
        .cd1_n   (cd1_n),
        .cd2_n   (cd2_n),
        .card_rdy(card_rdy),
        .io_rdy  (io_rdy),
        .cd1_s   (cd1_s),
        .cd2_s   (cd2_s),
        .rdy_s   (rdy_s),
        .iordy_s (iordy_s),
        .present (present),
        .det_evt (det_evt)
    );

    always_comb begin
        wr_lstat = reg_we && (reg_addr == ADDR_W'(RA_LSTAT));
        wr_len   = reg_we && (reg_addr == ADDR_W'(RA_LEN));
        wr_gstat = reg_we && (reg_addr == ADDR_W'(RA_GSTAT));
        wr_gsen  = reg_we && (reg_addr == ADDR_W'(RA_GSEN));
        wr_gsig  = reg_we && (reg_addr == ADDR_W'(RA_GSIG));

        l_set = '0;
        l_set[B_DET]  = det_evt;
        l_set[B_SCHG] = ev_stat_chg;
        l_set[B_MEM]  = ev_mem_mode;
        l_set[B_IO]   = ev_io_mode;
        l_set[B_IDE]  = ev_ide_mode;
        l_set[B_XERR] = ev_xfer_err;
        l_set[B_BUF]  = ev_buf_avail;
        l_set[B_DONE] = ev_xfer_done;

        g_set = '0;
        g_set[G_CARD] = l_pend;
        g_set[G_SIB]  = sib_evt;
    end

    cfh_local_tier #(.W(LW), .IMPL(LST_IMPL)) u_local (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (l_set),
        .wr_stat(wr_lstat),
        .wr_en  (wr_len),
        .wdata  (reg_wdata[LW-1:0]),
        .stat_o (l_stat),
        .en_o   (l_en),
        .pend_o (l_pend)
    );

    cfh_global_tier #(.G(GW)) u_global (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (g_set),
        .wr_stat(wr_gstat),
        .wr_sen (wr_gsen),
        .wr_sig (wr_gsig),
        .wdata  (reg_wdata[GW-1:0]),
        .stat_o (g_stat),
        .sen_o  (g_sen),
        .sig_o  (g_sig),
        .irq_o  (irq_o)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(RA_IFSTAT): begin
                reg_rdata[IF_PRES]  = present;
                reg_rdata[IF_CD1]   = cd1_s;
                reg_rdata[IF_CD2]   = cd2_s;
                reg_rdata[IF_RDY]   = rdy_s;
                reg_rdata[IF_IORDY] = iordy_s;
            end
            ADDR_W'(RA_LSTAT): reg_rdata[LW-1:0] = l_stat;
            ADDR_W'(RA_LEN):   reg_rdata[LW-1:0] = l_en;
            ADDR_W'(RA_GSTAT): reg_rdata[GW-1:0] = g_stat;
            ADDR_W'(RA_GSEN):  reg_rdata[GW-1:0] = g_sen;
            ADDR_W'(RA_GSIG):  reg_rdata[GW-1:0] = g_sig;
            default:           reg_rdata = '0;
        endcase
    end

    // R5: global card bit only rises after an enabled local bit was pending
    p_global_from_local_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(g_stat[G_CARD]) |-> $past(|(l_stat & l_en)));
    // R8: a presence change lands in local detect bit
    p_detect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        det_evt |=> l_stat[B_DET]);
    // R7: no signal-enable means no interrupt
    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (g_sig == '0) |-> !irq_o);
    // R10: quiet interrupt line straight after reset
    p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_o);
endmodule

// File: tb/sim_cfh_irq_aggregator.sv
`timescale 1ns/1ps
module sim_cfh_irq_aggregator;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic e_err = 0, e_buf = 0, e_done = 0, e_schg = 0, e_mem = 0, e_io = 0, e_ide = 0;
    logic sib = 0;
    logic cd1 = 1, cd2 = 1, rdy = 0, iordy = 0;
    logic irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cfh_irq_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_we(we),
        .reg_wdata(wdata), .reg_rdata(rdata),
        .ev_xfer_err(e_err), .ev_buf_avail(e_buf), .ev_xfer_done(e_done),
        .ev_stat_chg(e_schg), .ev_mem_mode(e_mem), .ev_io_mode(e_io),
        .ev_ide_mode(e_ide), .sib_evt(sib),
        .cd1_n(cd1), .cd2_n(cd2), .card_rdy(rdy), .io_rdy(iordy),
        .irq_o(irq)
    );

    // behavioural reference
    logic [3:0]  m_s1 = 4'b0011, m_s2 = 4'b0011;
    logic        m_pres = 0;
    logic [11:0] m_stat = 0, m_en = 0;
    logic [1:0]  m_gstat = 0, m_gsen = 0, m_gsig = 0;
    logic        t_pres, t_pend;
    logic [11:0] t_set, t_clr;
    logic [1:0]  t_gclr;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 4'b0011; m_s2 = 4'b0011; m_pres = 0;
            m_stat = 0; m_en = 0; m_gstat = 0; m_gsen = 0; m_gsig = 0;
        end else begin
            t_pres = !m_s2[0] && !m_s2[1];
            t_set  = {e_done, e_buf, e_err, e_ide, 4'b0000, e_io, e_mem, e_schg, t_pres != m_pres};
            t_clr  = (we && addr == 3'd1) ? wdata[11:0] : 12'h000;
            t_gclr = (we && addr == 3'd3) ? wdata[1:0] : 2'b00;
            t_pend = |(m_stat & m_en);
            m_stat = ((m_stat & ~t_clr) | t_set) & 12'hF0F;
            if (we && addr == 3'd2) m_en = wdata[11:0] & 12'hF0F;
            m_gstat = (m_gstat & ~t_gclr) | {sib, t_pend};
            if (we && addr == 3'd4) m_gsen = wdata[1:0];
            if (we && addr == 3'd5) m_gsig = wdata[1:0];
            m_pres = t_pres;
            m_s2 = m_s1;
            m_s1 = {iordy, rdy, cd2, cd1};
        end
    end

    function automatic logic [31:0] model_rd(input int a);
        case (a)
            0: return {25'd0, m_s2[3], m_s2[2], 1'b0, m_s2[1], m_s2[0], 1'b0, m_pres};
            1: return {20'd0, m_stat};
            2: return {20'd0, m_en};
            3: return {30'd0, m_gstat};
            4: return {30'd0, m_gsen};
            5: return {30'd0, m_gsig};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    task automatic sweep();
        logic [2:0] keep;
        string tg;
        keep = addr;
        for (int a = 0; a < 8; a++) begin
            addr = 3'(a);
            #0.1;
            case (a)
                0: tg = "R9 ifstat";
                1: tg = "R1 lstat";
                2: tg = "R4 len";
                3: tg = "R6 gstat";
                default: tg = "R4 map";
            endcase
            chk(tg, rdata, model_rd(a));
        end
        addr = keep;
        #0.1;
        chk("R7 irq", {31'd0, irq}, {31'd0, |(m_gstat & m_gsen & m_gsig)});
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        sweep();
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        logic [2:0] keep;
        keep = addr;
        addr = a;
        #0.1;
        v = rdata;
        addr = keep;
        #0.1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1;
        tick();
        we = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R10 reset state
        rd(3'd1, v); chk("R10 lstat", v, 32'h0);
        rd(3'd3, v); chk("R10 gstat", v, 32'h0);
        rd(3'd0, v); chk("R10 ifstat", v, 32'h0000000C);
        chk("R10 irq", {31'd0, irq}, 32'd0);

        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v); chk("R4 enable readback", v, 32'h0F0F);
        wr(3'd4, 32'd3);
        wr(3'd5, 32'd3);

        e_buf = 1; tick(); e_buf = 0;
        rd(3'd1, v); chk("R1 buf bit", v, 32'h400);
        rd(3'd3, v); chk("R5 not yet", v, 32'h0);
        tick();
        rd(3'd3, v); chk("R5 global set", v, 32'h1);
        chk("R7 irq on", {31'd0, irq}, 32'd1);

        wr(3'd1, 32'h0);
        rd(3'd1, v); chk("R2 zero write", v, 32'h400);
        wr(3'd3, 32'h1);
        rd(3'd3, v); chk("R3 global set beats clear", v, 32'h1);
        wr(3'd1, 32'h400);
        rd(3'd1, v); chk("R2 w1c", v, 32'h0);
        wr(3'd3, 32'h1);
        rd(3'd3, v); chk("R6 global w1c", v, 32'h0);
        chk("R7 irq off", {31'd0, irq}, 32'd0);

        e_err = 1; addr = 3'd1; wdata = 32'h200; we = 1;
        tick();
        e_err = 0; we = 0;
        rd(3'd1, v); chk("R3 local set beats clear", v, 32'h200);
        tick();
        wr(3'd5, 32'd0);
        chk("R7 sig masked", {31'd0, irq}, 32'd0);
        wr(3'd5, 32'd1);
        wr(3'd4, 32'd0);
        chk("R7 sen masked", {31'd0, irq}, 32'd0);
        wr(3'd4, 32'd1);
        chk("R7 both", {31'd0, irq}, 32'd1);
        wr(3'd1, 32'hFFF);
        wr(3'd3, 32'h3);
        rd(3'd3, v); chk("R6 cleared", v, 32'h0);

        wr(3'd2, 32'd0);
        e_mem = 1; tick(); e_mem = 0;
        rd(3'd1, v); chk("R1 set while disabled", v, 32'h004);
        tick(); tick();
        rd(3'd3, v); chk("R5 disabled no global", v, 32'h0);

        wr(3'd4, 32'd3); wr(3'd5, 32'd3);
        sib = 1; tick(); sib = 0;
        rd(3'd3, v); chk("R6 sibling", v, 32'h2);
        chk("R7 sibling irq", {31'd0, irq}, 32'd1);
        wr(3'd3, 32'h2);
        rd(3'd3, v); chk("R6 sibling clear", v, 32'h0);

        wr(3'd1, 32'hFFF);
        cd1 = 0;
        repeat (6) tick();
        rd(3'd1, v); chk("R8 one pin low", v, 32'h0);
        rd(3'd0, v); chk("R9 cd1 low", v, 32'h08);
        cd2 = 0;
        tick(); tick();
        rd(3'd1, v); chk("R8 not yet", v, 32'h0);
        tick();
        rd(3'd1, v); chk("R8 insertion", v, 32'h001);
        rd(3'd0, v); chk("R9 present", v, 32'h01);
        wr(3'd1, 32'h1);
        cd1 = 1;
        repeat (3) tick();
        rd(3'd1, v); chk("R8 removal", v, 32'h001);
        rdy = 1; iordy = 1;
        tick(); tick();
        rd(3'd0, v); chk("R9 ready bits", v, 32'h64);

        for (int i = 0; i < 600; i++) begin
            {e_err, e_buf, e_done, e_schg, e_mem, e_io, e_ide} = 7'($urandom_range(0, 127) & $urandom_range(0, 127));
            sib = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 15) == 0) cd1 = ~cd1;
            if ($urandom_range(0, 15) == 0) cd2 = ~cd2;
            if ($urandom_range(0, 31) == 0) rdy = ~rdy;
            if ($urandom_range(0, 31) == 0) iordy = ~iordy;
            we = ($urandom_range(0, 2) == 0);
            addr = 3'($urandom_range(0, 7));
            wdata = $urandom();
            tick();
        end
        {e_err, e_buf, e_done, e_schg, e_mem, e_io, e_ide} = '0;
        sib = 0; we = 0;
        tick();
        finish_run();
    end
endmodule